// File: doc/BRIEF.md
# Fully Associative Tag Store with Cyclic Replacement

This block holds the tag and valid state of a small fully associative cache. Every request carries a 32-bit byte address and an operation code. The address is stripped of its line-offset bits to form a line tag, and that tag is compared against every valid line at once. One cycle later the block reports whether the request hit. It also reports which line was involved, whether a line was allocated, and whether that allocation displaced valid data.

Reads and instruction fetches that miss claim the line named by a rotating victim pointer. The pointer then steps to the next line and wraps after the last one. Writes never allocate. A write that hits raises a data-update strobe aimed at the matched line. A write that misses leaves the store untouched, and the surrounding system sends it on to memory. The data array, the memory refill path and the write buffer sit outside this block.

The response is encoded as a registered state. The states are:
- `ST_IDLE`: no request.
- `ST_RD_HIT`: a read or fetch hit.
- `ST_WR_HIT`: a write hit.
- `ST_FILL`: a miss allocated into an empty line.
- `ST_EVICT`: a miss allocated over a valid line.
- `ST_WR_MISS`: a write miss.

Every cycle moves to the state chosen by the current request. When `req_valid` is low the next state is `ST_IDLE`. For a write, a hit leads to `ST_WR_HIT` and a miss to `ST_WR_MISS`. For any other operation, a hit leads to `ST_RD_HIT`, and a miss leads to `ST_EVICT` or `ST_FILL`, depending on the victim line's valid bit.

Top module: `rr_assoc_tags`

## Requirements
- R1: After reset, `rsp_valid` is 0, all lines are invalid, and the victim pointer is line 0. The first read miss therefore allocates line 0 with `rsp_evict`=0.
- R2: The tag is `req_addr` shifted right by log2(LINE_BYTES). Addresses that differ only in their offset bits refer to the same line.
- R3: A request whose tag equals the tag of any valid line hits. In the next cycle `rsp_valid`=1, `rsp_hit`=1 and `rsp_line` gives the matched line.
- R4: The operation codes are `req_op`=2'b00 for read, 2'b01 for write and 2'b10 for fetch. A read or fetch that misses writes its tag into the line named by the victim pointer and marks that line valid. The response has `rsp_alloc`=1 and `rsp_line` set to that line.
- R5: The victim pointer advances by one on every allocation and wraps from the last line to line 0. It holds its value on every other cycle.
- R6: On an allocation, `rsp_evict` equals the valid bit the victim line had before the allocation.
- R7: A write that hits answers with `rsp_hit`=1, `rsp_wr_upd`=1 and the matched line. It does not allocate.
- R8: A write that misses answers with `rsp_hit`=0 and `rsp_alloc`=0. It changes neither the tags, nor the valid bits, nor the pointer.
- R9: A cycle with `req_valid`=0 gives `rsp_valid`=0 in the next cycle and leaves all state unchanged.
- R10: Run the 16-access reference sequence. The default 32-byte cache with 8-byte lines gives 7 read/fetch misses, 1 write miss and 3 evictions. An 8192-byte cache with 32-byte lines gives 3 read/fetch misses and 0 evictions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 read, 01 write, 10 fetch |
| req_addr | input | 32 | Byte address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Request matched a valid line |
| rsp_alloc | output | 1 | A line was allocated for a read/fetch miss |
| rsp_evict | output | 1 | The allocated line previously held valid data |
| rsp_wr_upd | output | 1 | Write hit: update data of `rsp_line` |
| rsp_line | output | LINE_W | Matched or allocated line number |

## Verification
The reference sequence interleaves fetches from a code region with reads and writes to a data region. With four lines it checks hits inside a line at different offsets, pointer wrap with evictions, a write hit and a write miss. A second instance with 256 lines runs the same sequence, and the absence of evictions there separates capacity effects from tag errors. A write miss followed by a read of the same address shows that the write did not allocate. Idle cycles between requests show that the pointer holds. A reset after the store has been filled proves that the valid bits are cleared.

// File: rtl/rr_assoc_pkg.sv
package rr_assoc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_FETCH = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HIT,
        ST_WR_HIT,
        ST_FILL,
        ST_EVICT,
        ST_WR_MISS
    } rsp_state_e;

endpackage

// File: rtl/rr_tag_match.sv
module rr_tag_match #(
    parameter int LINES  = 4,
    parameter int TAG_W  = 29,
    parameter int LINE_W = 2
) (
    input  logic [TAG_W-1:0]  tag_q [LINES],
    input  logic [LINES-1:0]  valid_q,
    input  logic [TAG_W-1:0]  probe,
    output logic [LINES-1:0]  match_vec,
    output logic              any_hit,
    output logic [LINE_W-1:0] hit_line
);

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match_vec[g] = valid_q[g] && (tag_q[g] == probe);
    end

    assign any_hit = |match_vec;

    // lowest-numbered matching line wins
    always_comb begin
        hit_line = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_line = LINE_W'(i);
        end
    end

endmodule

// File: rtl/rr_victim_ptr.sv
module rr_victim_ptr #(
    parameter int LINE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [LINE_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (advance) ptr <= ptr + 1'b1;
    end

endmodule

// File: rtl/rr_assoc_tags.sv
module rr_assoc_tags
    import rr_assoc_pkg::*;
#(
    parameter int CACHE_BYTES = 32,
    parameter int LINE_BYTES  = 8,
    localparam int LINES  = CACHE_BYTES / LINE_BYTES,
    localparam int LINE_W = $clog2(LINES),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int TAG_W  = 32 - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [31:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_alloc,
    output logic              rsp_evict,
    output logic              rsp_wr_upd,
    output logic [LINE_W-1:0] rsp_line
);

    logic [TAG_W-1:0]  tag_q [LINES];
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  req_tag;
    logic [LINES-1:0]  match_vec;
    logic              any_hit;
    logic [LINE_W-1:0] hit_line;
    logic [LINE_W-1:0] vptr;
    logic              is_wr;
    logic              alloc;
    logic              unused_offset;

    rsp_state_e        state_q, state_d;
    logic [LINE_W-1:0] line_q, line_d;

    assign req_tag       = req_addr[31:OFF_W];
    assign unused_offset = ^req_addr[OFF_W-1:0];
    assign is_wr         = (op_e'(req_op) == OP_WRITE);
    assign alloc         = req_valid && !is_wr && !any_hit;

    rr_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_match (
        .tag_q     (tag_q),
        .valid_q   (valid_q),
        .probe     (req_tag),
        .match_vec (match_vec),
        .any_hit   (any_hit),
        .hit_line  (hit_line)
    );

    rr_victim_ptr #(.LINE_W(LINE_W)) u_vptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (alloc),
        .ptr     (vptr)
    );

    // tag array: no reset needed, guarded by valid bits
    always_ff @(posedge clk) begin
        if (alloc) tag_q[vptr] <= req_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q       <= '0;
        else if (alloc) valid_q[vptr] <= 1'b1;
    end

    // next response state
    always_comb begin
        state_d = ST_IDLE;
        line_d  = line_q;
        if (req_valid) begin
            if (is_wr) begin
                state_d = any_hit ? ST_WR_HIT : ST_WR_MISS;
                line_d  = any_hit ? hit_line : '0;
            end else if (any_hit) begin
                state_d = ST_RD_HIT;
                line_d  = hit_line;
            end else begin
                state_d = valid_q[vptr] ? ST_EVICT : ST_FILL;
                line_d  = vptr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
        end
    end

    // outputs decoded from registered state
    always_comb begin
        rsp_valid  = 1'b1;
        rsp_hit    = 1'b0;
        rsp_alloc  = 1'b0;
        rsp_evict  = 1'b0;
        rsp_wr_upd = 1'b0;
        rsp_line   = line_q;
        unique case (state_q)
            ST_IDLE:    rsp_valid = 1'b0;
            ST_RD_HIT:  rsp_hit   = 1'b1;
            ST_WR_HIT: begin
                rsp_hit    = 1'b1;
                rsp_wr_upd = 1'b1;
            end
            ST_FILL:    rsp_alloc = 1'b1;
            ST_EVICT: begin
                rsp_alloc = 1'b1;
                rsp_evict = 1'b1;
            end
            ST_WR_MISS: rsp_valid = 1'b1;
            default:    rsp_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/rr_assoc_tags_chk.sv
module rr_assoc_tags_chk #(
    parameter int LINES  = 4,
    parameter int LINE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [LINES-1:0]  match_vec,
    input logic              any_hit,
    input logic [LINE_W-1:0] vptr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_alloc,
    input logic              rsp_wr_upd,
    input logic [LINE_W-1:0] rsp_line
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid);

    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    a_r3_hit_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && any_hit) |=> (rsp_valid && rsp_hit && !rsp_alloc));

    a_r4_alloc_at_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'b01 && !any_hit) |=>
            (rsp_alloc && rsp_line == $past(vptr)));

    a_r5_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'b01 && !any_hit) |=>
            (vptr == LINE_W'($past(vptr) + 1'b1)));

    a_r7_upd_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_upd |-> (rsp_hit && rsp_valid));

    a_r8_write_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01) |=> (!rsp_alloc && $stable(vptr)));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(vptr)));

endmodule

bind rr_assoc_tags rr_assoc_tags_chk #(.LINES(LINES), .LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .match_vec  (match_vec),
    .any_hit    (any_hit),
    .vptr       (vptr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_alloc  (rsp_alloc),
    .rsp_wr_upd (rsp_wr_upd),
    .rsp_line   (rsp_line)
);

// File: tb/rr_assoc_tags_tb_top.sv
`timescale 1ns/1ps
module rr_assoc_tags_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0;

    logic       s_valid, s_hit, s_alloc, s_evict, s_upd;
    logic [1:0] s_line;
    logic       b_valid, b_hit, b_alloc, b_evict, b_upd;
    logic [7:0] b_line;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rr_assoc_tags dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .rsp_valid(s_valid), .rsp_hit(s_hit),
        .rsp_alloc(s_alloc), .rsp_evict(s_evict), .rsp_wr_upd(s_upd),
        .rsp_line(s_line)
    );

    rr_assoc_tags #(.CACHE_BYTES(8192), .LINE_BYTES(32)) dut_big_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .rsp_valid(b_valid), .rsp_hit(b_hit),
        .rsp_alloc(b_alloc), .rsp_evict(b_evict), .rsp_wr_upd(b_upd),
        .rsp_line(b_line)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive at a falling edge; response is sampled at the next falling edge
    task automatic access(input logic [1:0] op, input logic [31:0] addr);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk(s_valid == 1'b0, "R1 no response after reset", s_valid, 0);
        access(2'b00, 32'h0000_0100);
        chk(s_alloc == 1'b1, "R1 first read allocates", s_alloc, 1);
        chk(s_line == 2'd0, "R1 first victim is line 0", s_line, 0);
        chk(s_evict == 1'b0, "R1 first allocation evicts nothing", s_evict, 0);
    endtask

    task automatic t_trace();
        logic [1:0]  ops  [16] = '{2,0,2,0,2,0,2,0,2,0,2,1,2,0,2,1};
        logic [31:0] adr  [16] = '{32'h20000100, 32'h10000010, 32'h20000104, 32'h10000014,
                                   32'h20000108, 32'h10000020, 32'h2000010C, 32'h10000024,
                                   32'h20000110, 32'h10000030, 32'h20000114, 32'h10000030,
                                   32'h20000118, 32'h10000030, 32'h2000011C, 32'h10000130};
        bit          ehit [16] = '{0,0,1,1,0,0,1,1,0,0,1,1,0,1,1,0};
        int          elin [16] = '{0,1,0,1,2,3,2,3,0,1,0,1,2,1,2,0};
        bit          eev  [16] = '{0,0,0,0,0,0,0,0,1,1,0,0,1,0,0,0};
        int s_rm = 0, s_wm = 0, s_ev = 0, b_rm = 0, b_ev = 0;
        do_reset();
        for (int i = 0; i < 16; i++) begin
            bit wr;
            wr = (ops[i] == 2'b01);
            access(ops[i], adr[i]);
            // R2 R3: offset bits ignored, hit flagged
            chk(s_hit == ehit[i], $sformatf("R3 hit at step %0d", i), s_hit, ehit[i]);
            if (!wr || ehit[i])
                chk(s_line == 2'(elin[i]), $sformatf("R4 line at step %0d", i), s_line, elin[i]);
            chk(s_alloc == (!wr && !ehit[i]), $sformatf("R5 alloc at step %0d", i),
                s_alloc, int'(!wr && !ehit[i]));
            chk(s_evict == eev[i], $sformatf("R6 evict at step %0d", i), s_evict, eev[i]);
            chk(s_upd == (wr && ehit[i]), $sformatf("R7 update at step %0d", i),
                s_upd, int'(wr && ehit[i]));
            if (!s_hit && !wr) s_rm++;
            if (!s_hit && wr)  s_wm++;
            if (s_evict)       s_ev++;
            if (!b_hit && !wr) b_rm++;
            if (b_evict)       b_ev++;
        end
        chk(s_rm == 7, "R10 small read misses", s_rm, 7);
        chk(s_wm == 1, "R10 small write misses", s_wm, 1);
        chk(s_ev == 3, "R10 small evictions", s_ev, 3);
        chk(b_rm == 3, "R10 large read misses", b_rm, 3);
        chk(b_ev == 0, "R10 large evictions", b_ev, 0);
    endtask

    task automatic t_write_miss();
        do_reset();
        access(2'b01, 32'h0000_4000);
        chk(s_valid && !s_hit, "R8 write miss reported", s_hit, 0);
        chk(s_alloc == 1'b0, "R8 write miss no allocation", s_alloc, 0);
        access(2'b00, 32'h0000_4000);
        chk(s_hit == 1'b0, "R8 write left tag store unchanged", s_hit, 0);
        chk(s_line == 2'd0, "R8 pointer unmoved by write", s_line, 0);
        access(2'b01, 32'h0000_4004);
        chk(s_hit && s_upd, "R7 write hit strobe", s_upd, 1);
        chk(s_line == 2'd0 && !s_alloc, "R7 write hit line, no alloc", s_line, 0);
    endtask

    task automatic t_idle();
        repeat (3) begin
            @(negedge clk);
            chk(s_valid == 1'b0, "R9 idle gives no response", s_valid, 0);
        end
        access(2'b10, 32'h0000_8000);
        chk(s_alloc && s_line == 2'd1, "R9 pointer held across idle", s_line, 1);
        access(2'b10, 32'h0000_8010);
        chk(s_line == 2'd2 && !s_evict, "R5 pointer advances once per alloc", s_line, 2);
    endtask

    task automatic t_reset_clears();
        do_reset();
        access(2'b00, 32'h0000_4000);
        chk(s_hit == 1'b0, "R1 reset invalidated lines", s_hit, 0);
        chk(s_line == 2'd0 && !s_evict, "R1 reset returned pointer to 0", s_line, 0);
    endtask

    initial begin
        t_reset_state();
        t_trace();
        t_write_miss();
        t_idle();
        t_reset_clears();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule